// File: doc/BRIEF.md
# Video RAM Block-Copy Engine

This block copies data from anywhere in the 16-bit address space into video RAM on behalf of the processor. Software loads a source pointer and a destination pointer into four byte registers and then writes a fifth control register. That last write carries a chunk count and a mode bit, and it launches the engine. The low four bits of both pointers are cleared. The destination is also forced into the 8 KiB video window at 0x8000. A source pointer that falls inside video RAM itself makes the launch write a no-op.

There are two modes. In immediate mode the whole transfer runs at once while the processor is held off through `cpu_stall`. In line-paced mode the engine arms itself and moves one 16-byte chunk each time the video controller signals the start of a horizontal blanking interval on `hblank_start`. After every finished chunk or transfer, the advanced pointers are written back into the four pointer registers. The control register then reports progress: a remaining-chunk count with bit 7 clear while line-paced work is pending, or a value with bit 7 set once the engine is idle.

The sequencer is a five-state machine:
- `ST_IDLE` moves to `ST_READ` on an accepted immediate launch, or to `ST_ARMED` on an accepted line-paced launch.
- `ST_ARMED` moves to `ST_READ` on `hblank_start`, stays in `ST_ARMED` on a re-launch, and returns to `ST_IDLE` on a cancel.
- `ST_READ` always moves to `ST_WRITE`.
- `ST_WRITE` returns to `ST_READ` while bytes remain in the burst, and moves to `ST_FINISH` after the last byte.
- `ST_FINISH` writes the pointers back. It then returns to `ST_ARMED` while chunks remain, and to `ST_IDLE` otherwise.

Top module: `vdma_top`

## Requirements
- R1: After reset, the four pointer registers read 0x00 and the control register (select 4) reads 0xFF. `mem_rd`, `mem_wr` and `cpu_stall` are all low.
- R2: A launch uses source = {sel0, sel1} with the low 4 bits cleared, and destination = 0x8000 | ({sel2, sel3} & 0x1FF0). Select 0 and select 2 hold the high bytes.
- R3: A launch write is ignored entirely when the cleared source lies in 0x8000–0x9FFF. No byte moves, no stall is raised, and the control register keeps its value. A source of 0x7FF0 or 0xA000 is accepted.
- R4: An immediate launch (bit 7 of the written value is 0, engine idle) moves ((value & 0x7F) + 1) × 16 bytes. The engine reads at the source in one cycle and writes that same byte at the destination in the next cycle. Both addresses then advance by one.
- R5: `cpu_stall` is high for exactly 2 cycles per byte moved, and only while bytes are moving. The first read follows the launch edge directly.
- R6: When an immediate transfer ends, the control register reads (value & 0x7F) | 0x80. The pointer registers then hold the starting source and destination plus the byte count.
- R7: A launch with bit 7 set arms the engine. The control register then reads value & 0x7F, and nothing moves until `hblank_start`. Each pulse moves 16 bytes, decrements the control register, and writes the advanced pointers back to the pointer registers.
- R8: The chunk that takes the control register from 0x00 to 0xFF ends line-paced mode. The engine goes idle.
- R9: While armed, a launch write with bit 7 clear cancels the pending work and starts no immediate transfer. The control register then reads its remaining count with bit 7 set.
- R10: `hblank_start` has no effect while the engine is idle or while a chunk is already moving.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.
- R12: The pointer registers read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 source high, 1 source low, 2 destination high, 3 destination low, 4 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Data of the register chosen by `reg_sel` (combinational) |
| hblank_start | input | 1 | One-cycle pulse at the start of horizontal blanking |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| cpu_stall | output | 1 | Holds the processor off while bytes move |

## Verification
The assertions take for granted the following input behaviour:
- `mem_rdata` answers in the same cycle as `mem_rd`.
- No register write lands while `cpu_stall` is high.
- No register write lands in the single write-back cycle.

The stimulus respects these assumptions:
- The memory model is a purely combinational function of the address.
- Every register write is issued only after a fixed wait, worked out from the byte count, has let the engine return to rest.
- `hblank_start` pulses are placed both in idle periods and in the middle of a moving chunk, so the ignore rule is exercised.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } vdma_state_e;

    localparam int ADDR_W    = 16;
    localparam int BYTE_W    = 8;
    localparam int LEN_W     = BYTE_W - 1;
    localparam int PTR_REGS  = 4;
    localparam int SEL_W     = 3;
    localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;

    function automatic logic in_window(input logic [ADDR_W-1:0] a, input logic [2:0] tag);
        return a[ADDR_W-1:ADDR_W-3] == tag;
    endfunction
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
    import vdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_src,
    input  logic [ADDR_W-1:0] wb_dst,
    input  logic [BYTE_W-1:0] ctrl_val,
    output logic [ADDR_W-1:0] src_cfg,
    output logic [ADDR_W-1:0] dst_cfg,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int FLAT_W = PTR_REGS * BYTE_W;

    logic [FLAT_W-1:0] bank_flat;
    logic [FLAT_W-1:0] wb_flat;

    assign wb_flat = {wb_dst[7:0], wb_dst[15:8], wb_src[7:0], wb_src[15:8]};

    for (genvar g = 0; g < PTR_REGS; g++) begin : gen_ptr
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wb_valid) begin
                q <= wb_flat[g*BYTE_W +: BYTE_W];
            end else if (wr_en && sel == SEL_W'(g)) begin
                q <= wdata;
            end
        end
        assign bank_flat[g*BYTE_W +: BYTE_W] = q;
    end

    assign src_cfg = {bank_flat[7:0],   bank_flat[15:8]};
    assign dst_cfg = {bank_flat[23:16], bank_flat[31:24]};

    always_comb begin
        if (sel == SEL_CTRL) begin
            rd_data = ctrl_val;
        end else if (sel < SEL_W'(PTR_REGS)) begin
            rd_data = bank_flat[{sel[1:0], 3'b000} +: BYTE_W];
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
    import vdma_pkg::*;
#(
    parameter int         CHUNK_LOG2 = 4,
    parameter logic [2:0] VRAM_TAG   = 3'b100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_data,
    input  logic [ADDR_W-1:0] src_cfg,
    input  logic [ADDR_W-1:0] dst_cfg,
    input  logic              hblank_start,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              cpu_stall,
    output logic [BYTE_W-1:0] ctrl_val,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_src,
    output logic [ADDR_W-1:0] wb_dst
);
    localparam int CNT_W = LEN_W + CHUNK_LOG2;
    localparam logic [CNT_W-1:0] CHUNK_LAST = CNT_W'((1 << CHUNK_LOG2) - 1);

    vdma_state_e state, state_nx;
    logic [ADDR_W-1:0] src_q, dst_q, src_lat, dst_lat;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] data_q;
    logic              hb_mode;
    logic              src_bad, wr_ok, go_general, go_arm, go_cancel, last;

    assign src_lat    = {src_cfg[ADDR_W-1:CHUNK_LOG2], {CHUNK_LOG2{1'b0}}};
    assign dst_lat    = {VRAM_TAG, dst_cfg[ADDR_W-4:CHUNK_LOG2], {CHUNK_LOG2{1'b0}}};
    assign src_bad    = in_window(src_lat, VRAM_TAG);
    assign wr_ok      = ctrl_wr && !src_bad;
    assign go_general = wr_ok && !ctrl_data[7] && (state == ST_IDLE);
    assign go_arm     = wr_ok &&  ctrl_data[7] && (state == ST_IDLE || state == ST_ARMED);
    assign go_cancel  = wr_ok && !ctrl_data[7] && (state == ST_ARMED);
    assign last       = (cnt_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go_general)  state_nx = ST_READ;
                else if (go_arm) state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (go_cancel)         state_nx = ST_IDLE;
                else if (go_arm)       state_nx = ST_ARMED;
                else if (hblank_start) state_nx = ST_READ;
            end
            ST_READ:   state_nx = ST_WRITE;
            ST_WRITE:  state_nx = last ? ST_FINISH : ST_READ;
            ST_FINISH: state_nx = (hb_mode && ctrl_val != '0) ? ST_ARMED : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            cnt_q    <= '0;
            data_q   <= '0;
            ctrl_val <= '1;
            hb_mode  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_ARMED: begin
                    if (go_general) begin
                        src_q    <= src_lat;
                        dst_q    <= dst_lat;
                        cnt_q    <= {ctrl_data[LEN_W-1:0], {CHUNK_LOG2{1'b1}}};
                        ctrl_val <= {1'b0, ctrl_data[LEN_W-1:0]};
                        hb_mode  <= 1'b0;
                    end else if (go_arm) begin
                        src_q    <= src_lat;
                        dst_q    <= dst_lat;
                        ctrl_val <= {1'b0, ctrl_data[LEN_W-1:0]};
                        hb_mode  <= 1'b1;
                    end else if (go_cancel) begin
                        ctrl_val <= ctrl_val | 8'h80;
                        hb_mode  <= 1'b0;
                    end else if (state == ST_ARMED && hblank_start) begin
                        cnt_q <= CHUNK_LAST;
                    end
                end
                ST_READ: data_q <= mem_rdata;
                ST_WRITE: begin
                    src_q <= src_q + 1'b1;
                    dst_q <= dst_q + 1'b1;
                    if (!last) cnt_q <= cnt_q - 1'b1;
                end
                ST_FINISH: begin
                    if (hb_mode) begin
                        ctrl_val <= ctrl_val - 1'b1;
                        if (ctrl_val == '0) hb_mode <= 1'b0;
                    end else begin
                        ctrl_val <= ctrl_val | 8'h80;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        wb_valid  = 1'b0;
        mem_addr  = src_q;
        unique case (state)
            ST_READ:   mem_rd = 1'b1;
            ST_WRITE:  begin mem_wr = 1'b1; mem_addr = dst_q; end
            ST_FINISH: wb_valid = 1'b1;
            default: ;
        endcase
        cpu_stall = mem_rd | mem_wr;
        mem_wdata = data_q;
        wb_src    = src_q;
        wb_dst    = dst_q;
    end

    assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    assert_write_carries_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (mem_wr && mem_wdata == $past(mem_rdata)));
    assert_dst_in_vram_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) != ST_WRITE) |-> in_window(mem_addr == src_q ? dst_q : dst_q, VRAM_TAG));
    assert_src_outside_vram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && $past(state) != ST_WRITE) |-> !in_window(mem_addr, VRAM_TAG));
    assert_general_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && !hb_mode) |=> (ctrl_val[7] && state == ST_IDLE));
    assert_paced_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH && hb_mode && ctrl_val == '0) |=> (ctrl_val == 8'hFF && state == ST_IDLE));
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ctrl_wr) |=> !cpu_stall);
endmodule

// File: rtl/vdma_top.sv
module vdma_top
    import vdma_pkg::*;
#(
    parameter int CHUNK_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [2:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        hblank_start,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic        cpu_stall
);
    logic [ADDR_W-1:0] src_cfg, dst_cfg, wb_src, wb_dst;
    logic [BYTE_W-1:0] ctrl_val;
    logic              wb_valid, ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);

    vdma_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .wb_valid (wb_valid),
        .wb_src   (wb_src),
        .wb_dst   (wb_dst),
        .ctrl_val (ctrl_val),
        .src_cfg  (src_cfg),
        .dst_cfg  (dst_cfg),
        .rd_data  (reg_rdata)
    );

    vdma_ctrl #(.CHUNK_LOG2(CHUNK_LOG2)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_data    (reg_wdata),
        .src_cfg      (src_cfg),
        .dst_cfg      (dst_cfg),
        .hblank_start (hblank_start),
        .mem_rdata    (mem_rdata),
        .mem_rd       (mem_rd),
        .mem_wr       (mem_wr),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .cpu_stall    (cpu_stall),
        .ctrl_val     (ctrl_val),
        .wb_valid     (wb_valid),
        .wb_src       (wb_src),
        .wb_dst       (wb_dst)
    );

    assert_stall_matches_traffic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (mem_rd || mem_wr));
endmodule

// File: tb/vdma_top_tb.sv
module vdma_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        hblank_start = 1'b0;
    logic        mem_rd, mem_wr, cpu_stall;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0, n_stall = 0, cycles = 0;
    bit done = 0;
    logic [15:0] rlog [4096];
    logic [15:0] wlog_a [4096];
    logic [7:0]  wlog_d [4096];

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    assign mem_rdata = pat(mem_addr);

    vdma_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hblank_start(hblank_start),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .cpu_stall(cpu_stall)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd && n_rd < 4096) begin rlog[n_rd] = mem_addr; n_rd++; end
            if (mem_wr && n_wr < 4096) begin wlog_a[n_wr] = mem_addr; wlog_d[n_wr] = mem_wdata; n_wr++; end
            if (cpu_stall) n_stall++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] s, input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] s, output logic [7:0] v);
        reg_sel = s;
        #1;
        v = reg_rdata;
    endtask

    task automatic pulse();
        @(negedge clk);
        hblank_start = 1'b1;
        @(negedge clk);
        hblank_start = 1'b0;
    endtask

    task automatic set_ptrs(input logic [15:0] s, input logic [15:0] d);
        wr_reg(3'd0, s[15:8]); wr_reg(3'd1, s[7:0]);
        wr_reg(3'd2, d[15:8]); wr_reg(3'd3, d[7:0]);
    endtask

    task automatic read_ptrs(output logic [15:0] s, output logic [15:0] d);
        logic [7:0] a, b, c, e;
        rd_reg(3'd0, a); rd_reg(3'd1, b); rd_reg(3'd2, c); rd_reg(3'd3, e);
        s = {a, b}; d = {c, e};
    endtask

    task automatic verify(input int base, input int n, input logic [15:0] s0,
                          input logic [15:0] d0, input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < n; i++) begin
            logic [15:0] es = s0 + 16'(i);
            logic [15:0] ed = d0 + 16'(i);
            if (base + i >= 4096 || rlog[base+i] != es || wlog_a[base+i] != ed || wlog_d[base+i] != pat(es)) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(n_wr - base == n, {req, " byte count"}, n_wr - base, n);
        chk(bad == 0, {req, " byte order/data first bad index"}, first, -1);
    endtask

    task automatic run_general(input logic [15:0] s, input logic [15:0] d, input int len);
        int base = n_wr;
        int st0 = n_stall;
        int n = (len + 1) * 16;
        logic [15:0] s0 = s & 16'hFFF0;
        logic [15:0] d0 = (d & 16'h1FF0) | 16'h8000;
        logic [15:0] ps, pd;
        logic [7:0] cv;
        set_ptrs(s, d);
        wr_reg(3'd4, 8'(len));
        repeat (2 * n + 4) @(negedge clk);
        verify(base, n, s0, d0, "R4/R2");
        chk(n_stall - st0 == 2 * n, "R5 stall cycles", n_stall - st0, 2 * n);
        rd_reg(3'd4, cv);
        chk(cv == (8'(len) | 8'h80), "R6 control idle value", cv, 8'(len) | 8'h80);
        read_ptrs(ps, pd);
        chk(ps == s0 + 16'(n), "R6 source write-back", ps, s0 + 16'(n));
        chk(pd == d0 + 16'(n), "R6 destination write-back", pd, d0 + 16'(n));
    endtask

    initial begin
        logic [7:0] v;
        logic [15:0] ps, pd;
        int base, st0;

        // R1 reset state
        repeat (3) @(negedge clk);
        for (int r = 0; r < 4; r++) begin
            rd_reg(3'(r), v);
            chk(v == 8'h00, "R1 pointer reset", v, 0);
        end
        rd_reg(3'd4, v);
        chk(v == 8'hFF, "R1 control reset", v, 8'hFF);
        chk(!mem_rd && !mem_wr && !cpu_stall, "R1 strobes low in reset", {mem_rd, mem_wr, cpu_stall}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_rd && !mem_wr && !cpu_stall, "R1 strobes low after reset", {mem_rd, mem_wr, cpu_stall}, 0);

        // R12 pointer storage
        set_ptrs(16'hA5C3, 16'h3C5A);
        read_ptrs(ps, pd);
        chk(ps == 16'hA5C3, "R12 source readback", ps, 16'hA5C3);
        chk(pd == 16'h3C5A, "R12 destination readback", pd, 16'h3C5A);
        chk(n_wr == 0, "R12 pointer writes move nothing", n_wr, 0);

        // R4 R5 R6 R2 sweep of lengths with unaligned, dirty pointers
        for (int len = 0; len < 8; len++) begin
            run_general(16'h0A07 + 16'(len) * 16'h0F13, 16'hF3C9 + 16'(len) * 16'h0111, len);
        end
        // R3 accepted boundaries
        run_general(16'h7FF5, 16'h0000, 0);
        run_general(16'hA000, 16'h1800, 127);

        // R3 rejected sources
        foreach (ps[i]) ;
        for (int k = 0; k < 2; k++) begin
            base = n_wr; st0 = n_stall;
            set_ptrs(k == 0 ? 16'h8000 : 16'h9FFF, 16'h0100);
            wr_reg(3'd4, 8'h03);
            repeat (20) @(negedge clk);
            rd_reg(3'd4, v);
            chk(v == 8'hFF, "R3 control unchanged on reject", v, 8'hFF);
            chk(n_wr == base && n_stall == st0, "R3 nothing moves on reject", n_wr - base, 0);
        end

        // R7 R8 R10 line-paced transfer of three chunks
        set_ptrs(16'h4567, 16'h0AB3);
        base = n_wr; st0 = n_stall;
        wr_reg(3'd4, 8'h82);
        rd_reg(3'd4, v);
        chk(v == 8'h02, "R7 armed control value", v, 8'h02);
        repeat (20) @(negedge clk);
        chk(n_wr == base && n_stall == st0, "R7 nothing before pulse", n_wr - base, 0);
        pulse();
        repeat (40) @(negedge clk);
        verify(base, 16, 16'h4560, 16'h8AB0, "R7 first chunk");
        rd_reg(3'd4, v);
        chk(v == 8'h01, "R7 count after first chunk", v, 8'h01);
        read_ptrs(ps, pd);
        chk(ps == 16'h4570 && pd == 16'h8AC0, "R7 pointer write-back per chunk", {ps, pd}, 32'h45708AC0);
        pulse();
        repeat (3) @(negedge clk);
        pulse();
        repeat (40) @(negedge clk);
        chk(n_wr - base == 32, "R10 pulse during chunk ignored", n_wr - base, 32);
        rd_reg(3'd4, v);
        chk(v == 8'h00, "R7 count after second chunk", v, 8'h00);
        pulse();
        repeat (40) @(negedge clk);
        verify(base, 48, 16'h4560, 16'h8AB0, "R8 all chunks");
        rd_reg(3'd4, v);
        chk(v == 8'hFF, "R8 wrap to idle", v, 8'hFF);
        chk(n_stall - st0 == 96, "R5 paced stall cycles", n_stall - st0, 96);
        pulse();
        repeat (40) @(negedge clk);
        chk(n_wr - base == 48, "R10 pulse while idle ignored", n_wr - base, 48);

        // R9 cancel while armed
        set_ptrs(16'h2000, 16'h8100);
        base = n_wr;
        wr_reg(3'd4, 8'h83);
        pulse();
        repeat (40) @(negedge clk);
        rd_reg(3'd4, v);
        chk(v == 8'h02, "R9 count before cancel", v, 8'h02);
        wr_reg(3'd4, 8'h05);
        rd_reg(3'd4, v);
        chk(v == 8'h82, "R9 control after cancel", v, 8'h82);
        repeat (300) @(negedge clk);
        chk(n_wr - base == 16, "R9 cancel starts no immediate copy", n_wr - base, 16);
        pulse();
        repeat (40) @(negedge clk);
        chk(n_wr - base == 16, "R9 pulse after cancel ignored", n_wr - base, 16);

        // R3 reject while control holds a non-idle-reset value
        base = n_wr;
        set_ptrs(16'h85AB, 16'h0000);
        wr_reg(3'd4, 8'h01);
        repeat (20) @(negedge clk);
        rd_reg(3'd4, v);
        chk(v == 8'h82 && n_wr == base, "R3 reject keeps control value", v, 8'h82);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule